// File: doc/BRIEF.md
# SDRAM Mode Register Loader and Read Latency Tracker

This controller-side block owns two timing duties toward an SDRAM device. It assembles the mode register word from configuration fields, checks that the requested settings are legal, and issues the load strobe only when every bank reports idle. After the load it holds the controller's command-ready flag low for a programmed settling time. A request that arrives while banks are still open is kept pending, not lost. A newer legal request replaces a pending one.

The second duty is read capture timing. Each registered READ command is delayed by the CAS latency held in the active mode word. The block then raises an output-drive window flag one cycle ahead of the data and a capture-enable strobe for every data beat of the programmed burst. A READ that lands inside a running burst restarts the beat count, so reads spaced one burst apart produce an unbroken capture window.

Top module: `sdram_mode_ctl`

## Requirements
- R1: While and after reset: `mode_word` = 13'h030 (sequential, one beat, CAS latency 3), `mode_load` = 0, `cmd_ready` = 1, `drive_win` = 0, `cap_en` = 0, `cfg_err` = 0.
- R2: A loaded word has this layout: bits [2:0] burst code (0 = 1 beat, 1 = 2, 2 = 4, 3 = 8, 7 = full page), bit 3 burst type (1 = interleaved), bits [6:4] CAS latency value, bits [8:7] = 00, bit 9 write burst mode, bits [12:10] = 000.
- R3: `mode_load` is a one-cycle pulse, and `mode_word` changes only in that cycle. A load is issued only at an edge where `banks_idle` was sampled high. A legal request sampled at edge k is issued at edge k+1 at the earliest.
- R4: `cmd_ready` is low for exactly WAIT_CYC cycles, starting with the `mode_load` cycle.
- R5: A request is rejected if any of these holds: the CAS value is not 2 or 3, the mode bits are non-zero, the burst code is 4, 5 or 6, or a full-page burst is requested with interleaving. A rejected request never loads. It sets `cfg_err` one cycle later and leaves any pending legal request intact. A legal request clears `cfg_err`.
- R6: With CAS latency 2, a READ sampled at edge n gives `drive_win` from the cycle after edge n+1 and `cap_en` from the cycle after edge n+2.
- R7: With CAS latency 3, the same READ gives `drive_win` from the cycle after edge n+2 and `cap_en` from the cycle after edge n+3.
- R8: `cap_en` stays high for exactly the burst beat count: 1, 2, 4 or 8, or 2**COL_W for a full page. `drive_win` falls together with `cap_en`.
- R9: READs spaced exactly one burst apart give a continuous `cap_en`. A READ inside a running burst restarts the count from its own start.
- R10: While banks are busy, a legal request stays pending, and a newer legal request replaces the older one.
- R11: No load is issued in the cycle after a cycle with `cmd_ready` low. A request made just after a load is issued WAIT_CYC+1 cycles after the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bl | input | 3 | Requested burst length code |
| cfg_ilv | input | 1 | Requested burst type, 1 = interleaved |
| cfg_cas | input | 3 | Requested CAS latency value |
| cfg_opm | input | 2 | Requested operating mode, must be 0 |
| cfg_wbm | input | 1 | Requested write burst mode bit |
| ld_req | input | 1 | Load request, sampled each edge |
| banks_idle | input | 1 | All banks precharged and idle |
| rd_cmd | input | 1 | READ command registered at this edge |
| mode_word | output | 13 | Active mode register word |
| mode_load | output | 1 | Mode register load strobe |
| cmd_ready | output | 1 | Controller may issue the next command |
| drive_win | output | 1 | Device output drive window |
| cap_en | output | 1 | Read data capture enable, one per beat |
| cfg_err | output | 1 | Last request was rejected |

## Verification
The hardest state to reach from the ports is a burst that is interrupted or chained while a new CAS latency or burst length has just been loaded. Reaching it needs a load, an idle bank flag and READ pulses placed at exact edge offsets. The bench first loads each configuration through the normal request path. It then issues READ pulses at offsets measured from the pulse edge, one burst apart and mid-burst. It also holds `banks_idle` low across several requests to build the pending and replacement cases.

// File: rtl/sdrmr_pkg.sv
package sdrmr_pkg;

    localparam int MW = 13;

    localparam logic [MW-1:0] MODE_RST = 13'h030;

    typedef enum logic [2:0] {
        BL_ONE  = 3'd0,
        BL_TWO  = 3'd1,
        BL_FOUR = 3'd2,
        BL_OCT  = 3'd3,
        BL_PAGE = 3'd7
    } bl_code_e;

    typedef struct packed {
        logic [2:0] bl;
        logic       ilv;
        logic [2:0] cas;
        logic [1:0] opm;
        logic       wbm;
    } mode_cfg_t;

    function automatic logic cfg_legal(mode_cfg_t c);
        logic ok;
        ok = 1'b1;
        if (c.cas != 3'd2 && c.cas != 3'd3) ok = 1'b0;
        if (c.opm != 2'b00) ok = 1'b0;
        if (c.bl inside {3'd4, 3'd5, 3'd6}) ok = 1'b0;
        if (c.bl == BL_PAGE && c.ilv) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [MW-1:0] compose(mode_cfg_t c);
        return {3'b000, c.wbm, 2'b00, c.cas, c.ilv, c.bl};
    endfunction

    function automatic logic word_cas3(logic [MW-1:0] w);
        return w[4];
    endfunction

endpackage

// File: rtl/sdrmr_cfg_check.sv
module sdrmr_cfg_check
    import sdrmr_pkg::*;
(
    input  mode_cfg_t       cfg,
    output logic            legal,
    output logic [MW-1:0]   word
);
    always_comb begin
        legal = cfg_legal(cfg);
        word  = compose(cfg);
    end
endmodule

// File: rtl/sdrmr_load_seq.sv
module sdrmr_load_seq
    import sdrmr_pkg::*;
#(
    parameter int WAIT_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            req_legal,
    input  logic [MW-1:0]   req_word,
    input  logic            banks_idle,
    output logic [MW-1:0]   mode_word,
    output logic            mode_load,
    output logic            cmd_ready,
    output logic            cfg_err
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic            pend_q;
    logic [MW-1:0]   pend_word_q;
    logic [CW-1:0]   wait_q;
    logic            issue;

    // Issue only when a request waits, banks are idle and the settle time is over
    always_comb issue = pend_q && banks_idle && (wait_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_word_q <= MODE_RST;
            wait_q      <= '0;
            mode_word   <= MODE_RST;
            mode_load   <= 1'b0;
            cfg_err     <= 1'b0;
        end else begin
            mode_load <= issue;
            if (issue) begin
                mode_word <= pend_word_q;
                wait_q    <= CW'(WAIT_CYC);
            end else if (wait_q != '0) begin
                wait_q    <= wait_q - 1'b1;
            end

            if (req && req_legal) begin
                pend_q      <= 1'b1;
                pend_word_q <= req_word;
                cfg_err     <= 1'b0;
            end else begin
                if (issue) pend_q <= 1'b0;
                if (req) cfg_err <= 1'b1;
            end
        end
    end

    always_comb cmd_ready = (wait_q == '0);

endmodule

// File: rtl/sdrmr_rd_track.sv
module sdrmr_rd_track
    import sdrmr_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_cmd,
    input  logic        cas3,
    input  logic [2:0]  bl_code,
    output logic        drive_win,
    output logic        cap_en
);
    localparam int RW   = COL_W + 1;
    localparam int PAGE = 1 << COL_W;

    // Delay line: stage 2 feeds stage 1, stage 1 feeds the drive-start flag.
    // A latency-3 READ enters at stage 2, a latency-2 READ at stage 1.
    logic        stg2_q, stg1_q, start_q;
    logic [RW-1:0] left_q;
    logic [RW-1:0] beats;

    always_comb begin
        unique case (bl_code)
            BL_ONE:  beats = RW'(1);
            BL_TWO:  beats = RW'(2);
            BL_FOUR: beats = RW'(4);
            BL_OCT:  beats = RW'(8);
            default: beats = RW'(PAGE);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg2_q  <= 1'b0;
            stg1_q  <= 1'b0;
            start_q <= 1'b0;
            left_q  <= '0;
        end else begin
            stg2_q  <= rd_cmd && cas3;
            stg1_q  <= (rd_cmd && !cas3) || stg2_q;
            start_q <= stg1_q;
            if (start_q)
                left_q <= beats;
            else if (left_q != '0)
                left_q <= left_q - 1'b1;
        end
    end

    always_comb begin
        cap_en    = (left_q != '0);
        drive_win = start_q || cap_en;
    end

endmodule

// File: rtl/sdram_mode_ctl.sv
module sdram_mode_ctl
    import sdrmr_pkg::*;
#(
    parameter int WAIT_CYC = 4,
    parameter int COL_W    = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cfg_bl,
    input  logic        cfg_ilv,
    input  logic [2:0]  cfg_cas,
    input  logic [1:0]  cfg_opm,
    input  logic        cfg_wbm,
    input  logic        ld_req,
    input  logic        banks_idle,
    input  logic        rd_cmd,
    output logic [12:0] mode_word,
    output logic        mode_load,
    output logic        cmd_ready,
    output logic        drive_win,
    output logic        cap_en,
    output logic        cfg_err
);
    mode_cfg_t       req_cfg;
    logic            req_legal;
    logic [MW-1:0]   req_word;

    always_comb req_cfg = '{bl: cfg_bl, ilv: cfg_ilv, cas: cfg_cas,
                            opm: cfg_opm, wbm: cfg_wbm};

    sdrmr_cfg_check u_check (
        .cfg   (req_cfg),
        .legal (req_legal),
        .word  (req_word)
    );

    sdrmr_load_seq #(.WAIT_CYC(WAIT_CYC)) u_load (
        .clk        (clk),
        .rst        (rst),
        .req        (ld_req),
        .req_legal  (req_legal),
        .req_word   (req_word),
        .banks_idle (banks_idle),
        .mode_word  (mode_word),
        .mode_load  (mode_load),
        .cmd_ready  (cmd_ready),
        .cfg_err    (cfg_err)
    );

    sdrmr_rd_track #(.COL_W(COL_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_cmd    (rd_cmd),
        .cas3      (word_cas3(mode_word)),
        .bl_code   (mode_word[2:0]),
        .drive_win (drive_win),
        .cap_en    (cap_en)
    );

endmodule

// File: rtl/sdram_mode_ctl_chk.sv
module sdram_mode_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        banks_idle,
    input logic [12:0] mode_word,
    input logic        mode_load,
    input logic        cmd_ready,
    input logic        drive_win,
    input logic        cap_en
);
    p_fixed_fields_r2: assert property (@(posedge clk) disable iff (rst)
        mode_word[8:7] == 2'b00 && mode_word[12:10] == 3'b000);

    p_cas_legal_r5: assert property (@(posedge clk) disable iff (rst)
        mode_word[6:4] == 3'd2 || mode_word[6:4] == 3'd3);

    p_load_idle_r3: assert property (@(posedge clk) disable iff (rst)
        mode_load |-> $past(banks_idle));

    p_load_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mode_load |=> !mode_load);

    p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !mode_load |-> $stable(mode_word));

    p_ready_low_r4: assert property (@(posedge clk) disable iff (rst)
        mode_load |-> !cmd_ready);

    p_no_load_busy_r11: assert property (@(posedge clk) disable iff (rst)
        !cmd_ready |=> !mode_load);

    p_cap_in_drive_r8: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> drive_win);

    p_drive_lead_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_en) |-> $past(drive_win));
endmodule

bind sdram_mode_ctl sdram_mode_ctl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .banks_idle (banks_idle),
    .mode_word  (mode_word),
    .mode_load  (mode_load),
    .cmd_ready  (cmd_ready),
    .drive_win  (drive_win),
    .cap_en     (cap_en)
);

// File: tb/tb_sdram_mode_ctl.sv
module tb_sdram_mode_ctl;
    localparam int WAIT_CYC = 4;
    localparam int COL_W    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_bl = 3'd0;
    logic        cfg_ilv = 1'b0;
    logic [2:0]  cfg_cas = 3'd2;
    logic [1:0]  cfg_opm = 2'd0;
    logic        cfg_wbm = 1'b0;
    logic        ld_req = 1'b0;
    logic        banks_idle = 1'b1;
    logic        rd_cmd = 1'b0;
    logic [12:0] mode_word;
    logic        mode_load, cmd_ready, drive_win, cap_en, cfg_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_mode_ctl #(.WAIT_CYC(WAIT_CYC), .COL_W(COL_W)) dut (.*);

    typedef struct packed {
        logic [2:0]  bl;
        logic        ilv;
        logic [2:0]  cas;
        logic [1:0]  opm;
        logic        wbm;
        logic        err;
        logic [12:0] word;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{3'd2, 1'b0, 3'd2, 2'd0, 1'b0, 1'b0, 13'h022},
        '{3'd3, 1'b1, 3'd3, 2'd0, 1'b1, 1'b0, 13'h23B},
        '{3'd7, 1'b0, 3'd3, 2'd0, 1'b0, 1'b0, 13'h037},
        '{3'd0, 1'b1, 3'd2, 2'd0, 1'b1, 1'b0, 13'h228},
        '{3'd0, 1'b0, 3'd4, 2'd0, 1'b0, 1'b1, 13'h228},
        '{3'd1, 1'b0, 3'd2, 2'd1, 1'b0, 1'b1, 13'h228},
        '{3'd5, 1'b0, 3'd2, 2'd0, 1'b0, 1'b1, 13'h228},
        '{3'd7, 1'b1, 3'd3, 2'd0, 1'b0, 1'b1, 13'h228},
        '{3'd1, 1'b0, 3'd2, 2'd0, 1'b0, 1'b0, 13'h021}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one request; returns at the negedge after the sampling edge
    task automatic request(input logic [2:0] bl, input logic ilv, input logic [2:0] cas,
                           input logic [1:0] opm, input logic wbm);
        cfg_bl = bl; cfg_ilv = ilv; cfg_cas = cas; cfg_opm = opm; cfg_wbm = wbm;
        ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
    endtask

    // One READ (gap = 0) or two READs gap cycles apart; checks every cycle
    task automatic reads(input int m, input int bl, input int gap, input string req);
        int last;
        int bad;
        bad = 0;
        last = (gap > 0 ? gap : 0) + m + bl - 1;
        rd_cmd = 1'b1;
        @(negedge clk);
        rd_cmd = 1'b0;
        for (int i = 0; i <= last + 3; i++) begin
            bit ec, ed;
            ec = (i >= m) && (i <= last);
            ed = (i >= m - 1) && (i <= last);
            if (cap_en !== ec || drive_win !== ed) begin
                if (bad == 0)
                    chk(1'b0, req, {i, cap_en, drive_win}, {i, ec, ed});
                bad++;
            end
            rd_cmd = (gap > 0 && i == gap - 1);
            @(negedge clk);
        end
        if (bad == 0) chk(1'b1, req, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int gapc;
        cyc(3);
        chk(mode_word == 13'h030 && !mode_load && cmd_ready && !drive_win && !cap_en && !cfg_err,
            "R1 reset state", {mode_word, mode_load, cmd_ready, drive_win, cap_en, cfg_err},
            {13'h030, 5'b01000});
        rst = 1'b0;
        @(negedge clk);
        chk(mode_word == 13'h030 && cmd_ready && !cap_en, "R1 after release",
            mode_word, 13'h030);

        // Vector table: R2 layout and R5 rejection
        for (int v = 0; v < NV; v++) begin
            request(VT[v].bl, VT[v].ilv, VT[v].cas, VT[v].opm, VT[v].wbm);
            chk(cfg_err == VT[v].err && !mode_load, "R5 error flag", cfg_err, VT[v].err);
            @(negedge clk);
            chk(mode_load == !VT[v].err, "R3 load strobe", mode_load, !VT[v].err);
            chk(mode_word == VT[v].word, "R2 word layout", mode_word, VT[v].word);
            cyc(WAIT_CYC + 2);
        end

        // R4: ready low for WAIT_CYC cycles from the load cycle
        request(3'd2, 1'b0, 3'd2, 2'd0, 1'b0);
        @(negedge clk);
        begin
            int lowc;
            lowc = 0;
            for (int i = 0; i < WAIT_CYC + 4; i++) begin
                if (!cmd_ready) lowc++;
                @(negedge clk);
            end
            chk(lowc == WAIT_CYC, "R4 ready low length", lowc, WAIT_CYC);
        end

        // R3/R10: pending while busy, newer request replaces
        banks_idle = 1'b0;
        request(3'd3, 1'b0, 3'd3, 2'd0, 1'b0);
        request(3'd1, 1'b1, 3'd3, 2'd0, 1'b0);
        request(3'd0, 1'b0, 3'd7, 2'd0, 1'b0);
        cyc(4);
        chk(!mode_load && mode_word == 13'h022, "R3 no load while busy", mode_word, 13'h022);
        chk(cfg_err == 1'b1, "R5 reject keeps pending", cfg_err, 1);
        banks_idle = 1'b1;
        @(negedge clk);
        chk(mode_load && mode_word == 13'h039, "R10 newest request loads", mode_word, 13'h039);
        cyc(WAIT_CYC + 2);

        // R11: request right after a load waits for settle time
        request(3'd2, 1'b0, 3'd2, 2'd0, 1'b0);
        @(negedge clk);
        cfg_bl = 3'd3; ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
        gapc = 1;
        while (!mode_load && gapc < 40) begin @(negedge clk); gapc++; end
        chk(gapc == WAIT_CYC + 1, "R11 load spacing", gapc, WAIT_CYC + 1);
        chk(mode_word == 13'h023, "R11 second word", mode_word, 13'h023);
        cyc(WAIT_CYC + 2);

        // Read timing: CL2 BL4
        request(3'd2, 1'b0, 3'd2, 2'd0, 1'b0); cyc(WAIT_CYC + 2);
        reads(2, 4, 0, "R6 CL2 single burst");
        reads(2, 4, 4, "R9 chained bursts");
        reads(2, 4, 2, "R9 interrupted burst");
        // CL3 BL8
        request(3'd3, 1'b1, 3'd3, 2'd0, 1'b0); cyc(WAIT_CYC + 2);
        reads(3, 8, 0, "R7 CL3 single burst");
        reads(3, 8, 8, "R9 chained CL3");
        // BL1 and BL2
        request(3'd0, 1'b0, 3'd3, 2'd0, 1'b0); cyc(WAIT_CYC + 2);
        reads(3, 1, 0, "R8 one beat");
        request(3'd1, 1'b0, 3'd2, 2'd0, 1'b0); cyc(WAIT_CYC + 2);
        reads(2, 2, 0, "R8 two beats");
        // Full page
        request(3'd7, 1'b0, 3'd2, 2'd0, 1'b0); cyc(WAIT_CYC + 2);
        reads(2, 1 << COL_W, 0, "R8 full page");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule